// File: doc/BRIEF.md
# EEPROM Block-Lock Write Protection

This block decides whether each host write to an 8 KB byte-wide nonvolatile array may be committed. The array is split into eight 1 KB blocks. Two protection tiers apply. The lower tier is a global software protection mode. While this mode is on, every data write must be preceded at once by a three-write unlock command. The upper tier is an eight-bit lock mask with one bit per block. A locked block refuses every write, even one that follows a valid unlock command.

The block observes the host write stream: a one-cycle write strobe with its address and data. It decodes the command sequences from that stream and drives `wr_permit_o` in the same cycle as each write. The array controller uses that signal to accept or drop the write. A six-write command turns the protection mode off. Another six-write command loads a new lock mask. The mask and the enable flag start from parameter values at reset. These values stand in for the nonvolatile configuration.

Top module: `eeprom_wr_guard`

## Requirements
- R1: The block index is `wr_addr_i[12:10]`. Mask bit n set to 1 means block n is locked. Any write to a locked block sees `wr_permit_o` = 0, whatever the protection mode or the decoder state.
- R2: While `prot_en_o` = 0, every write to an unlocked block is permitted. This includes command writes.
- R3: While `prot_en_o` = 1, a write to an unlocked block is permitted only when it directly follows the writes (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0xA0). Exactly one write is armed by each such sequence. Later writes are refused until the sequence is sent again.
- R4: Completing the three-write sequence ending in (0x1555,0xA0) sets `prot_en_o` to 1 from the next cycle.
- R5: The writes (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0x80), (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0x20) clear `prot_en_o` from the next cycle.
- R6: The same five-write prefix followed by a write to address 0x1C00 loads `lock_mask_o` with that write's data bits [7:0] from the next cycle. The first write after the load uses the new mask.
- R7: A write that does not match the expected next step of a sequence returns the decoder to idle and changes no configuration. Cycles without a strobe change nothing.
- R8: After reset, `prot_en_o` and `lock_mask_o` equal the parameters PROT_RST and LOCK_RST. `wr_permit_o` is 0 in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | 13 | Write address |
| wr_data_i | input | 8 | Write data |
| wr_permit_o | output | 1 | Current write may be committed |
| prot_en_o | output | 1 | Software protection mode active |
| lock_mask_o | output | 8 | Per-block lock bits, 1 = locked |

## Verification
The bench targets a locked block written straight after a valid unlock sequence. A design that let the unlock override the lock would permit that write. It also sends a second write after a single unlock. A decoder that stayed armed would permit both writes instead of one. Broken sequences are used too, including one broken at the fifth step of the lock command. A design that did not return to idle there would load a stray mask or accept an unarmed write. Last, the bench writes to a newly locked block in the cycle right after the mask loads. A late update would let that first write through.

// File: rtl/eeprom_wr_guard_pkg.sv
package eeprom_wr_guard_pkg;
  localparam int unsigned CMD_ADDR_A = 'h1555;
  localparam int unsigned CMD_ADDR_B = 'h0AAA;
  localparam int unsigned CMD_ADDR_L = 'h1C00;
  localparam int unsigned CMD_D_KEY1 = 'hAA;
  localparam int unsigned CMD_D_KEY2 = 'h55;
  localparam int unsigned CMD_D_ARM  = 'hA0;
  localparam int unsigned CMD_D_EXT  = 'h80;
  localparam int unsigned CMD_D_OFF  = 'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_ARM, ST_X3, ST_X4, ST_X5
  } seq_st_e;
endpackage

// File: rtl/eeprom_seq_dec.sv
module eeprom_seq_dec
  import eeprom_wr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              armed_o,
  output logic              set_prot_o,
  output logic              clr_prot_o,
  output logic              load_mask_o
);
  seq_st_e st_q, st_d;

  logic a_a, a_b, a_l;
  always_comb begin
    a_a = wr_addr_i == ADDR_W'(CMD_ADDR_A);
    a_b = wr_addr_i == ADDR_W'(CMD_ADDR_B);
    a_l = wr_addr_i == ADDR_W'(CMD_ADDR_L);
  end

  function automatic logic hit(input logic adr, input logic [DATA_W-1:0] d,
                               input int unsigned v);
    return adr && (d == DATA_W'(v));
  endfunction

  always_comb begin
    st_d        = st_q;
    set_prot_o  = 1'b0;
    clr_prot_o  = 1'b0;
    load_mask_o = 1'b0;
    if (wr_valid_i) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (hit(a_a, wr_data_i, CMD_D_KEY1)) st_d = ST_K1;
        ST_K1:   if (hit(a_b, wr_data_i, CMD_D_KEY2)) st_d = ST_K2;
        ST_K2: begin
          if (hit(a_a, wr_data_i, CMD_D_ARM)) begin
            st_d       = ST_ARM;
            set_prot_o = 1'b1;
          end else if (hit(a_a, wr_data_i, CMD_D_EXT)) begin
            st_d = ST_X3;
          end
        end
        ST_ARM:  st_d = ST_IDLE;  // one armed write consumed
        ST_X3:   if (hit(a_a, wr_data_i, CMD_D_KEY1)) st_d = ST_X4;
        ST_X4:   if (hit(a_b, wr_data_i, CMD_D_KEY2)) st_d = ST_X5;
        ST_X5: begin
          if (hit(a_a, wr_data_i, CMD_D_OFF)) clr_prot_o = 1'b1;
          else if (a_l)                       load_mask_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == ST_ARM);
endmodule

// File: rtl/eeprom_cfg_reg.sv
module eeprom_cfg_reg #(
  parameter int unsigned      NUM_BLK  = 8,
  parameter logic             PROT_RST = 1'b0,
  parameter logic [NUM_BLK-1:0] LOCK_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_prot_i,
  input  logic               clr_prot_i,
  input  logic               load_mask_i,
  input  logic [NUM_BLK-1:0] mask_data_i,
  output logic               prot_en_o,
  output logic [NUM_BLK-1:0] lock_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_en_o   <= PROT_RST;
      lock_mask_o <= LOCK_RST;
    end else begin
      if (set_prot_i)      prot_en_o <= 1'b1;
      else if (clr_prot_i) prot_en_o <= 1'b0;
      if (load_mask_i)     lock_mask_o <= mask_data_i;
    end
  end
endmodule

// File: rtl/eeprom_permit.sv
module eeprom_permit #(
  parameter int unsigned NUM_BLK = 8,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input  logic               wr_valid_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [NUM_BLK-1:0] lock_mask_i,
  input  logic               prot_en_i,
  input  logic               armed_i,
  output logic               locked_o,
  output logic               permit_o
);
  logic [NUM_BLK-1:0] blk_hit;
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign blk_hit[g] = (blk_i == BLK_W'(g));
  end

  assign locked_o = |(blk_hit & lock_mask_i);
  assign permit_o = wr_valid_i && !locked_o && (!prot_en_i || armed_i);
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard #(
  parameter int unsigned        ADDR_W   = 13,
  parameter int unsigned        DATA_W   = 8,
  parameter int unsigned        NUM_BLK  = 8,
  parameter logic               PROT_RST = 1'b0,
  parameter logic [NUM_BLK-1:0] LOCK_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               wr_permit_o,
  output logic               prot_en_o,
  output logic [NUM_BLK-1:0] lock_mask_o
);
  localparam int unsigned BLK_W = $clog2(NUM_BLK);

  logic armed, set_prot, clr_prot, load_mask, locked;

  eeprom_seq_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i, .rst_ni, .wr_valid_i, .wr_addr_i, .wr_data_i,
    .armed_o(armed), .set_prot_o(set_prot), .clr_prot_o(clr_prot),
    .load_mask_o(load_mask)
  );

  eeprom_cfg_reg #(.NUM_BLK(NUM_BLK), .PROT_RST(PROT_RST), .LOCK_RST(LOCK_RST)) u_cfg (
    .clk_i, .rst_ni, .set_prot_i(set_prot), .clr_prot_i(clr_prot),
    .load_mask_i(load_mask), .mask_data_i(wr_data_i[NUM_BLK-1:0]),
    .prot_en_o, .lock_mask_o
  );

  eeprom_permit #(.NUM_BLK(NUM_BLK)) u_perm (
    .wr_valid_i, .blk_i(wr_addr_i[ADDR_W-1 -: BLK_W]), .lock_mask_i(lock_mask_o),
    .prot_en_i(prot_en_o), .armed_i(armed), .locked_o(locked), .permit_o(wr_permit_o)
  );
endmodule

// File: rtl/eeprom_wr_guard_chk.sv
module eeprom_wr_guard_chk #(
  parameter int unsigned NUM_BLK = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic               wr_permit_o,
  input logic               prot_en_o,
  input logic [NUM_BLK-1:0] lock_mask_o,
  input logic               armed,
  input logic               locked,
  input logic               load_mask,
  input logic               set_prot
);
  a_r1_lock_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && locked) |-> !wr_permit_o);
  a_r2_open_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !locked && !prot_en_o) |-> wr_permit_o);
  a_r3_need_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && prot_en_o && !armed) |-> !wr_permit_o);
  a_r3_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && armed) |=> !armed);
  a_r4_prot_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_prot |=> prot_en_o);
  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($stable(lock_mask_o) && $stable(prot_en_o)));
  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_mask |=> $stable(lock_mask_o));
  a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> !wr_permit_o);
endmodule

bind eeprom_wr_guard eeprom_wr_guard_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i, .rst_ni, .wr_valid_i, .wr_permit_o, .prot_en_o, .lock_mask_o,
  .armed, .locked, .load_mask, .set_prot
);

// File: tb/eeprom_wr_guard_bench.sv
module eeprom_wr_guard_bench;
  logic        clk = 0, rst_n = 0;
  logic        wv = 0;
  logic [12:0] wa = '0;
  logic [7:0]  wd = '0;
  logic        permit, prot;
  logic [7:0]  mask;

  eeprom_wr_guard #(.PROT_RST(1'b1), .LOCK_RST(8'h81)) u_eeprom_wr_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd),
    .wr_permit_o(permit), .prot_en_o(prot), .lock_mask_o(mask)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int m_st = 0;  // 0 idle,1 k1,2 k2,3 armed,4 x3,5 x4,6 x5
  bit m_prot = 1;
  bit [7:0] m_mask = 8'h81;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_permit(bit [12:0] a);
    return !m_mask[a[12:10]] && (!m_prot || m_st == 3);
  endfunction

  function automatic void m_step(bit [12:0] a, bit [7:0] d);
    int n = 0;
    case (m_st)
      0: if (a == 13'h1555 && d == 8'hAA) n = 1;
      1: if (a == 13'h0AAA && d == 8'h55) n = 2;
      2: if (a == 13'h1555 && d == 8'hA0) begin n = 3; m_prot = 1; end
         else if (a == 13'h1555 && d == 8'h80) n = 4;
      4: if (a == 13'h1555 && d == 8'hAA) n = 5;
      5: if (a == 13'h0AAA && d == 8'h55) n = 6;
      6: if (a == 13'h1555 && d == 8'h20) m_prot = 0;
         else if (a == 13'h1C00) m_mask = d;
      default: n = 0;
    endcase
    m_st = n;
  endfunction

  task automatic wr(string tag, bit [12:0] a, bit [7:0] d);
    @(negedge clk);
    wv = 1; wa = a; wd = d;
    #1 check(tag, permit, m_permit(a));
    @(posedge clk);
    m_step(a, d);
    @(negedge clk);
    wv = 0;
    #1;
    check(tag, prot, m_prot);
    check(tag, mask, m_mask);
  endtask

  task automatic unlock3(); wr("R4", 13'h1555, 8'hAA); wr("R4", 13'h0AAA, 8'h55);
                            wr("R4", 13'h1555, 8'hA0); endtask
  task automatic pre5(); wr("R5", 13'h1555, 8'hAA); wr("R5", 13'h0AAA, 8'h55);
                         wr("R5", 13'h1555, 8'h80); wr("R5", 13'h1555, 8'hAA);
                         wr("R5", 13'h0AAA, 8'h55); endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk); #1;
    check("R8 reset prot", prot, 1);
    check("R8 reset mask", mask, 8'h81);
    check("R8 idle permit", permit, 0);
    wr("R3 unarmed", 13'h0400, 8'h11);
    unlock3(); wr("R3 armed", 13'h0400, 8'h22);
    wr("R3 second", 13'h0401, 8'h23);
    unlock3(); wr("R1 locked blk7", 13'h1C05, 8'h33);
    unlock3(); wr("R1 locked blk0", 13'h0010, 8'h34);
    pre5(); wr("R5 off", 13'h1555, 8'h20);
    check("R5 prot clr", prot, 0);
    wr("R2 open blk2", 13'h0800, 8'h44);
    wr("R2 open blk3", 13'h0C00, 8'h45);
    wr("R1 blk0 still locked", 13'h0001, 8'h46);
    pre5(); wr("R6 load", 13'h1C00, 8'h04);
    check("R6 mask", mask, 8'h04);
    wr("R6 blk2 now locked", 13'h0900, 8'h47);
    wr("R6 blk0 now open", 13'h0002, 8'h48);
    unlock3(); check("R4 prot set", prot, 1);
    wr("R3 armed after enable", 13'h1000, 8'h49);
    wr("R7 brk", 13'h1555, 8'hAA); wr("R7 brk", 13'h0AAA, 8'h33);
    wr("R7 brk", 13'h1555, 8'hA0); wr("R7 after break", 13'h0400, 8'h4A);
    wr("R7 brk5", 13'h1555, 8'hAA); wr("R7 brk5", 13'h0AAA, 8'h55);
    wr("R7 brk5", 13'h1555, 8'h80); wr("R7 brk5", 13'h1555, 8'hAA);
    wr("R7 brk5", 13'h0AAA, 8'h00); wr("R7 stray load", 13'h1C00, 8'hFF);
    check("R7 mask kept", mask, 8'h04);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1 check("R8 no strobe", permit, 0);
    end
    for (int i = 0; i < 3000; i++) begin
      bit [12:0] a; bit [7:0] d;
      case ($urandom_range(0, 5))
        0: begin a = 13'h1555; d = 8'hAA; end
        1: begin a = 13'h0AAA; d = 8'h55; end
        2: begin a = 13'h1555; d = ($urandom_range(0, 1) != 0) ? 8'hA0 : 8'h80; end
        3: begin a = 13'h1555; d = 8'h20; end
        4: begin a = 13'h1C00; d = 8'($urandom); end
        default: begin a = 13'($urandom); d = 8'($urandom); end
      endcase
      wr("R7 random", a, d);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule